// File: doc/BRIEF.md
# Sampled Von Neumann Debiaser

This block turns a raw one-bit entropy source into a stream of unbiased bits. While enabled, a counter divides the clock and takes one sample of the raw input every programmed period. Samples are grouped in pairs, and a differing pair yields one output bit. An identical pair yields nothing. A bypass setting passes every sample straight to the output, and in that setting a minimum sample period applies so the source has time to decorrelate.

A run monitor counts how many successive samples are equal. When the count reaches the configured run length, a sticky error flags a stuck source. The flag holds until it is cleared through a dedicated input. The configuration inputs are plain levels that a register elsewhere in the chip drives.

States and transitions. The pair tracker has three states: PS_OFF (source disabled), PS_FIRST (waiting for the first sample of a pair) and PS_SECOND (first sample held, waiting for the second). Its transitions are:
- PS_OFF or PS_FIRST to PS_SECOND on a sample without bypass.
- PS_SECOND to PS_FIRST on a sample, or when bypass is raised.
- Any state to PS_OFF when enable drops.
- PS_OFF to PS_FIRST when enable is high with no sample.

The run monitor has two states: RM_EMPTY (no previous sample) and RM_TRACK. It moves to RM_TRACK on any sample, and back to RM_EMPTY when enable drops or bypass is set.

Top module: `vn_debias_sampler`

## Requirements
- R1: After reset, out_valid, out_bit and stuck_err are all 0.
- R2: With enable high from edge 0, samples of raw_bit are taken at rising edges P-1, 2P-1, and so on, where P is the effective period. Outside bypass, P is sample_period, and a programmed 0 acts as 1.
- R3: While src_en is 0, no sample is taken and no output is produced. Dropping src_en discards a held half-pair and empties the run count.
- R4: Outside bypass, a sample pair first=0, second=1 produces out_bit 0, and a pair first=1, second=0 produces out_bit 1.
- R5: Outside bypass, the pairs 0,0 and 1,1 produce no output.
- R6: out_valid is high for exactly one cycle per produced bit. It is high in the cycle after the edge at which the deciding sample is taken.
- R7: With bypass set, every sample is output directly as out_bit.
- R8: With bypass set, the effective period is the larger of sample_period and 17. Values 0 to 16 act as 17.
- R9: Outside bypass, stuck_err is set at the edge of the 32nd consecutive identical sample, whether all zeros or all ones. A differing sample restarts the run count at 1.
- R10: With bypass set, the identical-run check is skipped, and stuck_err is never set by samples.
- R11: stuck_err stays set, including while the source is disabled, until stuck_clr is high at a clock edge. It is cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 1 | Enables sampling of the raw source |
| sample_period | input | 32 | Clock cycles between two samples |
| bypass | input | 1 | Skip pairing and the run check, output every sample |
| raw_bit | input | 1 | Raw entropy bit |
| stuck_clr | input | 1 | Clears the stuck-source flag |
| out_bit | output | 1 | Debiased output bit |
| out_valid | output | 1 | One-cycle strobe marking out_bit |
| stuck_err | output | 1 | Sticky stuck-source flag |

## Verification
The hardest situation to reach is a run boundary: exactly 31 identical samples must leave the flag low, and the 32nd must set it. A single differing sample part-way through must restart the count, and the run must cross pair boundaries while the scoreboard still tracks which pairs produce output. The stimulus sets the period to 0 so that every clock edge is a sample. It then holds raw_bit for precisely one window per sample, so every sample is placed on a known edge. The bench's own run model predicts the flag after each window, and it clears the flag while the source is disabled, so a clear never coincides with a sample.

// File: rtl/vnd_pkg.sv
package vnd_pkg;

    // Pair tracker states
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_FIRST  = 2'd1,
        PS_SECOND = 2'd2
    } pair_state_t;

    // Run monitor states
    typedef enum logic {
        RM_EMPTY = 1'b0,
        RM_TRACK = 1'b1
    } run_state_t;

endpackage

// File: rtl/vnd_sample_timer.sv
module vnd_sample_timer #(
    parameter int CNT_W   = 32,
    parameter int BYP_MIN = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bypass,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE_P = CNT_W'(1);
    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(BYP_MIN);

    logic [CNT_W-1:0] eff_period;
    logic [CNT_W-1:0] cnt_q;

    // Effective period: 0 acts as 1, bypass enforces the floor
    always_comb begin
        eff_period = (period == '0) ? ONE_P : period;
        if (bypass && (eff_period < MIN_P)) begin
            eff_period = MIN_P;
        end
    end

    assign tick = en && (cnt_q >= (eff_period - ONE_P));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE_P;
        end
    end

endmodule

// File: rtl/vnd_pair_fsm.sv
module vnd_pair_fsm
    import vnd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bypass,
    input  logic tick,
    input  logic sample,
    output logic out_bit,
    output logic out_valid
);
    pair_state_t state_q, state_d;
    logic        first_q;
    logic        take_first;
    logic        take_second;
    logic        take_direct;

    assign take_direct = en && tick && bypass;
    assign take_first  = en && tick && !bypass && (state_q != PS_SECOND);
    assign take_second = en && tick && !bypass && (state_q == PS_SECOND);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF, PS_FIRST: begin
                if (!en) begin
                    state_d = PS_OFF;
                end else if (tick && !bypass) begin
                    state_d = PS_SECOND;
                end else begin
                    state_d = PS_FIRST;
                end
            end
            PS_SECOND: begin
                if (!en) begin
                    state_d = PS_OFF;
                end else if (bypass || tick) begin
                    state_d = PS_FIRST;
                end else begin
                    state_d = PS_SECOND;
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b0;
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (take_first) begin
                first_q <= sample;
            end
            if (take_direct) begin
                out_valid <= 1'b1;
                out_bit   <= sample;
            end else if (take_second && (sample != first_q)) begin
                out_valid <= 1'b1;
                out_bit   <= first_q;
            end
        end
    end

    // R7: raising bypass abandons a held half-pair
    a_r7_bypass_leaves_second: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SECOND && bypass) |=> (state_q != PS_SECOND));

    // R3: dropping enable returns the tracker to PS_OFF
    a_r3_disable_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == PS_OFF));

endmodule

// File: rtl/vnd_run_monitor.sv
module vnd_run_monitor
    import vnd_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bypass,
    input  logic tick,
    input  logic sample,
    input  logic clr,
    output logic err
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    run_state_t      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             last_q;
    logic             take;
    logic             set_err;

    assign take = en && tick && !bypass;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RM_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and run count
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            RM_EMPTY: begin
                if (!en || bypass) begin
                    run_d = '0;
                end else if (tick) begin
                    state_d = RM_TRACK;
                    run_d   = RUN_ONE;
                end
            end
            RM_TRACK: begin
                if (!en || bypass) begin
                    state_d = RM_EMPTY;
                    run_d   = '0;
                end else if (tick) begin
                    if (sample == last_q) begin
                        run_d = (run_q >= RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;
                    end else begin
                        run_d = RUN_ONE;
                    end
                end
            end
            default: begin
                state_d = RM_EMPTY;
                run_d   = '0;
            end
        endcase
    end

    assign set_err = take && (run_d >= RUN_MAX);

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
            err    <= 1'b0;
        end else begin
            run_q <= run_d;
            if (take) begin
                last_q <= sample;
            end
            if (set_err) begin
                err <= 1'b1;
            end else if (clr) begin
                err <= 1'b0;
            end
        end
    end

    // R9: the flag rises only with a full run recorded
    a_r9_rise_on_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (run_q == RUN_MAX));

    // R10: bypass never raises the flag
    a_r10_bypass_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && bypass) |=> !err);

    // R11: the flag holds without a clear
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);

endmodule

// File: rtl/vn_debias_sampler.sv
module vn_debias_sampler #(
    parameter int CNT_W   = 32,
    parameter int RUN_LEN = 32,
    parameter int BYP_MIN = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic [CNT_W-1:0] sample_period,
    input  logic             bypass,
    input  logic             raw_bit,
    input  logic             stuck_clr,
    output logic             out_bit,
    output logic             out_valid,
    output logic             stuck_err
);
    logic tick;

    vnd_sample_timer #(
        .CNT_W   (CNT_W),
        .BYP_MIN (BYP_MIN)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (src_en),
        .bypass (bypass),
        .period (sample_period),
        .tick   (tick)
    );

    vnd_pair_fsm u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (src_en),
        .bypass    (bypass),
        .tick      (tick),
        .sample    (raw_bit),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    vnd_run_monitor #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (src_en),
        .bypass (bypass),
        .tick   (tick),
        .sample (raw_bit),
        .clr    (stuck_clr),
        .err    (stuck_err)
    );

    // R6: one-cycle strobe
    a_r6_single_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: output only follows an enabled cycle
    a_r3_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(src_en));

endmodule

// File: tb/vn_debias_sampler_bench.sv
module vn_debias_sampler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic [31:0] sample_period = 32'd4;
    logic        bypass = 1'b0;
    logic        raw_bit = 1'b0;
    logic        stuck_clr = 1'b0;
    logic        out_bit;
    logic        out_valid;
    logic        stuck_err;

    always #2.5 clk = ~clk;   // 200 MHz

    vn_debias_sampler u_vn_debias_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_en        (src_en),
        .sample_period (sample_period),
        .bypass        (bypass),
        .raw_bit       (raw_bit),
        .stuck_clr     (stuck_clr),
        .out_bit       (out_bit),
        .out_valid     (out_valid),
        .stuck_err     (stuck_err)
    );

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    int unsigned valid_seen = 0;
    bit          done = 1'b0;

    // Scoreboard queues
    logic  exp_q[$];
    string tag_q[$];

    // Bench reference model state
    bit          m_pending = 1'b0;
    bit          m_first = 1'b0;
    int unsigned m_run = 0;
    bit          m_last = 1'b0;
    bit          m_err = 1'b0;
    int unsigned m_period = 1;

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Monitor: pops an expected item for each strobe
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            valid_seen++;
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R5 unexpected output actual=%0b expected=none", out_bit);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_bit !== e) begin
                    miscompares++;
                    $display("FAIL %s actual=%0b expected=%0b", t, out_bit, e);
                end
            end
        end
    end

    // Configure with the source disabled, then enable (R2, R8)
    task automatic configure(input logic [31:0] p, input logic byp);
        src_en = 1'b0;
        repeat (2) @(negedge clk);
        sample_period = p;
        bypass = byp;
        m_pending = 1'b0;
        m_run = 0;
        m_period = (p == 0) ? 1 : p;
        if (byp && m_period < 17) m_period = 17;
        src_en = 1'b1;
    endtask

    // Driver: hold one sample for a whole window, predict outputs
    task automatic apply_sample(input logic b);
        raw_bit = b;
        if (bypass) begin
            exp_q.push_back(b); tag_q.push_back("R7");
            m_run = 0;
        end else begin
            if (m_pending) begin
                if (b != m_first) begin
                    exp_q.push_back(m_first);
                    tag_q.push_back("R4");
                end
                m_pending = 1'b0;
            end else begin
                m_first = b;
                m_pending = 1'b1;
            end
            if (m_run > 0 && b == m_last) m_run = (m_run >= 32) ? 32 : m_run + 1;
            else m_run = 1;
            m_last = b;
            if (m_run >= 32) m_err = 1'b1;
        end
        repeat (m_period) @(negedge clk);
        check(bypass ? "R10" : "R9", stuck_err, m_err);
    endtask

    task automatic apply_run(input logic b, input int n);
        for (int i = 0; i < n; i++) apply_sample(b);
    endtask

    task automatic disable_src(input int cycles);
        src_en = 1'b0;
        m_pending = 1'b0;
        m_run = 0;
        for (int i = 0; i < cycles; i++) begin
            raw_bit = ~raw_bit;
            @(negedge clk);
        end
    endtask

    task automatic clear_err;
        stuck_clr = 1'b1;
        @(negedge clk);
        stuck_clr = 1'b0;
        m_err = 1'b0;
        check("R11", stuck_err, 1'b0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", out_valid, 1'b0);
        check("R1", out_bit, 1'b0);
        check("R1", stuck_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out_valid, 1'b0);

        // R2, R4, R5: period 4, mixed pairs
        configure(32'd4, 1'b0);
        apply_sample(0); apply_sample(1);
        apply_sample(1); apply_sample(0);
        apply_sample(1); apply_sample(1);
        apply_sample(0); apply_sample(0);
        apply_sample(1); apply_sample(0);
        apply_sample(0); apply_sample(1);

        // R2: period 0 acts as 1
        configure(32'd0, 1'b0);
        apply_sample(1); apply_sample(0);
        apply_sample(0); apply_sample(1);
        apply_sample(0); apply_sample(0);
        apply_sample(1); apply_sample(0);

        // R3: drop enable mid-pair, no output while disabled, half discarded
        configure(32'd4, 1'b0);
        apply_sample(0);
        seen = valid_seen;
        disable_src(20);
        vectors++;
        if (valid_seen != seen) begin
            miscompares++;
            $display("FAIL R3 outputs while disabled actual=%0d expected=0", valid_seen - seen);
        end
        src_en = 1'b1;
        apply_sample(1); apply_sample(0);

        // R8, R7: bypass with small period acts as 17
        configure(32'd3, 1'b1);
        apply_sample(1); apply_sample(0); apply_sample(0);
        apply_sample(1); apply_sample(1);
        // R10: a long identical run in bypass raises nothing
        apply_run(1'b1, 40);
        // R8: period above the floor is used as is
        configure(32'd20, 1'b1);
        apply_sample(0); apply_sample(1);

        // R9: 31 ones keep the flag low, the 32nd sets it
        configure(32'd1, 1'b0);
        apply_run(1'b1, 31);
        check("R9", stuck_err, 1'b0);
        apply_sample(1);
        check("R9", stuck_err, 1'b1);

        // R11: flag holds while disabled, clears on stuck_clr
        disable_src(10);
        check("R11", stuck_err, 1'b1);
        clear_err();

        // R9: all zeros also trip the check
        configure(32'd0, 1'b0);
        apply_run(1'b0, 32);
        check("R9", stuck_err, 1'b1);
        disable_src(2);
        clear_err();

        // R9: a differing sample restarts the count
        configure(32'd1, 1'b0);
        apply_run(1'b1, 10);
        apply_sample(0);
        apply_run(1'b1, 31);
        check("R9", stuck_err, 1'b0);
        apply_sample(1);
        check("R9", stuck_err, 1'b1);

        disable_src(4);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R6 missing outputs actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule